// File: doc/BRIEF.md
# Zero-Overhead Nested Loop Sequencer

This block produces the instruction fetch address of a signal-processing core and runs hardware loops so that the jump from the last instruction of a loop back to its first instruction costs no cycle. When the instruction at the current fetch address is a loop-start command, the decoder asserts `loop_start` and supplies two values: the address of the last instruction of the loop body and a four-bit termination condition. The sequencer saves the first body address on a PC stack and saves the end address and condition on a separate loop stack.

On every cycle the current fetch address is compared with the end address of the innermost loop. When they are equal, the selected condition is evaluated in that same cycle. The next fetch address is either the saved top of the loop or the address that follows the loop, and in the second case both stacks are popped. A 14-bit iteration counter with its own four-entry save stack provides count-based exit for nested counted loops. Loops nest four deep, and a body can be a single instruction long. A push onto a full stack is dropped and raises a sticky error flag.

Top module: `zol_sequencer`

## Requirements
- R1: After a synchronous active-low reset, `fetch_addr` is 0, `loop_depth` is 0, `count_now` is 0 and `overflow_err` is 0.
- R2: While the fetch address does not equal the innermost loop's end address (or no loop is open), the fetch address increases by exactly one each cycle.
- R3: A `loop_start` in the cycle at fetch address A opens a loop whose first body instruction is A+1. `loop_depth` rises by one in the next cycle.
- R4: When the fetch address equals the innermost end address and the condition is false, the next cycle's fetch address is that loop's first body address, with no idle cycle in between.
- R5: When the fetch address equals the innermost end address and the condition is true, the next fetch address is end+1 and `loop_depth` falls by one.
- R6: Condition code 4'b0000 means counter expired. Code 4'b1iii terminates when `status_flags[iii]` is 1. Code 4'b0iii with iii not 000 terminates when `status_flags[iii]` is 0. Only the innermost loop's code and the flags in the end-address cycle matter.
- R7: `count_load` sets the 14-bit counter to `count_value`, visible in the next cycle. In a loop with code 0000, each end-address cycle with a counter above 1 decrements the counter. A counter equal to 1 at the end address means expired.
- R8: A `count_load` while a count is already active saves the old count. When a counted loop exits, the saved count comes back. If no count is saved, the counter returns to 0.
- R9: Four loops can be open at once, and a loop whose end address equals its start address plus one repeats that single instruction.
- R10: A loop start with four loops open, or a count save with four counts saved, is ignored. It sets `overflow_err`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loop_start | input | 1 | Current instruction opens a loop |
| loop_end_addr | input | 14 | Address of the last loop instruction |
| loop_cond | input | 4 | Termination condition code |
| count_load | input | 1 | Current instruction loads the iteration counter |
| count_value | input | 14 | Value to load into the counter |
| status_flags | input | 8 | Arithmetic status flags for condition tests |
| fetch_addr | output | 14 | Current instruction fetch address |
| loop_depth | output | 3 | Number of open loops |
| count_now | output | 14 | Current iteration counter |
| overflow_err | output | 1 | Sticky stack overflow error |

## Verification
The assertions assume that the decoder never asserts `loop_start` or `count_load` in a cycle where the fetch address equals the innermost end address. They also assume that the PC and loop stacks are never pushed and popped in the same cycle. Every stimulus sequence in the bench places loop-start and counter-load commands only on addresses inside a loop body, never on the last body instruction. Each command is driven for one cycle only and then returned to zero. Flags are set only in the cycles where they are meant to decide an exit. The overflow case pushes a fifth loop at a non-end address, so the dropped push is never mixed with a pop.

// File: rtl/zol_pkg.sv
// Package: shared widths and condition encodings for the loop sequencer.
// Assumes an 8-entry status flag vector selected by a 3-bit field.
package zol_pkg;
    localparam int COND_W  = 4;
    localparam int FLAG_W  = 8;
    typedef logic [COND_W-1:0] cond_t;
    localparam cond_t COND_COUNT_DONE = 4'b0000;
endpackage

// File: rtl/zol_lifo.sv
// Module: small last-in first-out stack with level count.
// Assumes push and pop are not asserted together; a push when full and a
// pop when empty are ignored. Entry storage is not cleared on reset; the
// level counter is, which empties the stack.
module zol_lifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         pop,
    input  logic [W-1:0]                 din,
    output logic [W-1:0]                 top,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty
);
    localparam int LW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [LW-1:0] lvl_q;
    logic [IW-1:0] top_idx;

    assign full    = (lvl_q == LW'(DEPTH));
    assign empty   = (lvl_q == '0);
    assign level   = lvl_q;
    assign top_idx = IW'(lvl_q - 1'b1);
    assign top     = mem[top_idx];

    // Level counter: up on accepted push, down on accepted pop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lvl_q <= '0;
        else if (push && !full)
            lvl_q <= lvl_q + 1'b1;
        else if (pop && !empty)
            lvl_q <= lvl_q - 1'b1;
    end

    // One write port per entry, selected by the current level.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (push && !full && (lvl_q == LW'(g)))
                mem[g] <= din;
        end
    end

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_level_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q <= LW'(DEPTH));
    assert_full_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && full && push && !pop) |=> full);
endmodule

// File: rtl/zol_cond.sv
// Module: termination condition evaluator.
// Code 0000 selects counter expiry; 1iii selects flag iii set;
// 0iii (iii nonzero) selects flag iii clear. Purely combinational.
module zol_cond
    import zol_pkg::*;
(
    input  cond_t              code,
    input  logic [FLAG_W-1:0]  flags,
    input  logic               count_expired,
    output logic               terminate
);
    logic flag_sel;

    assign flag_sel = flags[code[2:0]];

    // Decode the condition code into a single terminate bit.
    always_comb begin
        if (code == COND_COUNT_DONE)
            terminate = count_expired;
        else if (code[3])
            terminate = flag_sel;
        else
            terminate = !flag_sel;
    end
endmodule

// File: rtl/zol_sequencer.sv
// Module: fetch address sequencer with zero-overhead nested hardware loops.
// Assumes the decoder does not issue loop_start or count_load on the last
// instruction of the innermost loop. Exit and loop-back decisions are made
// in the cycle whose fetch address equals the innermost end address.
module zol_sequencer
    import zol_pkg::*;
#(
    parameter int AW    = 14,
    parameter int CW    = 14,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         loop_start,
    input  logic [AW-1:0]                loop_end_addr,
    input  logic [COND_W-1:0]            loop_cond,
    input  logic                         count_load,
    input  logic [CW-1:0]                count_value,
    input  logic [FLAG_W-1:0]            status_flags,
    output logic [AW-1:0]                fetch_addr,
    output logic [$clog2(DEPTH+1)-1:0]   loop_depth,
    output logic [CW-1:0]                count_now,
    output logic                         overflow_err
);
    localparam int LW  = $clog2(DEPTH + 1);
    localparam int LSW = AW + COND_W;

    logic [AW-1:0]  pc_q;
    logic [CW-1:0]  cnt_q;
    logic           cnt_active_q;
    logic           err_q;

    logic [AW-1:0]  pc_top;
    logic [LW-1:0]  pc_lvl;
    logic           pc_full, pc_empty;
    logic [LSW-1:0] ls_top;
    logic [LW-1:0]  ls_lvl;
    logic           ls_full, ls_empty;
    logic [CW-1:0]  cs_top;
    logic [LW-1:0]  cs_lvl;
    logic           cs_full, cs_empty;

    logic [AW-1:0]  end_top;
    cond_t          cond_top;
    logic           at_end, term, loop_back, loop_exit, ce_loop;
    logic           cs_push, cs_pop;
    logic [AW-1:0]  pc_next;

    assign end_top   = ls_top[AW-1:0];
    assign cond_top  = ls_top[LSW-1:AW];
    assign at_end    = !ls_empty && (pc_q == end_top);
    assign loop_back = at_end && !term;
    assign loop_exit = at_end && term;
    assign ce_loop   = (cond_top == COND_COUNT_DONE);
    assign cs_push   = count_load && cnt_active_q;
    assign cs_pop    = loop_exit && ce_loop && !cs_empty && !count_load;

    zol_cond u_cond (
        .code          (cond_top),
        .flags         (status_flags),
        .count_expired (cnt_q == CW'(1)),
        .terminate     (term)
    );

    zol_lifo #(.W(AW), .DEPTH(DEPTH)) u_pc_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (loop_start),
        .pop   (loop_exit),
        .din   (pc_q + 1'b1),
        .top   (pc_top),
        .level (pc_lvl),
        .full  (pc_full),
        .empty (pc_empty)
    );

    zol_lifo #(.W(LSW), .DEPTH(DEPTH)) u_loop_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (loop_start),
        .pop   (loop_exit),
        .din   ({loop_cond, loop_end_addr}),
        .top   (ls_top),
        .level (ls_lvl),
        .full  (ls_full),
        .empty (ls_empty)
    );

    zol_lifo #(.W(CW), .DEPTH(DEPTH)) u_count_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (cs_push),
        .pop   (cs_pop),
        .din   (cnt_q),
        .top   (cs_top),
        .level (cs_lvl),
        .full  (cs_full),
        .empty (cs_empty)
    );

    // Next fetch address: loop top on a repeat, otherwise sequential.
    always_comb begin
        if (loop_back)
            pc_next = pc_top;
        else
            pc_next = pc_q + 1'b1;
    end

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else
            pc_q <= pc_next;
    end

    // Iteration counter: load, decrement at counted loop end, restore on exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            cnt_active_q <= 1'b0;
        end else if (count_load) begin
            cnt_q        <= count_value;
            cnt_active_q <= 1'b1;
        end else if (at_end && ce_loop) begin
            if (!term)
                cnt_q <= cnt_q - 1'b1;
            else if (!cs_empty)
                cnt_q <= cs_top;
            else begin
                cnt_q        <= '0;
                cnt_active_q <= 1'b0;
            end
        end
    end

    // Sticky overflow flag for dropped pushes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if ((loop_start && ls_full) || (cs_push && cs_full))
            err_q <= 1'b1;
    end

    assign fetch_addr   = pc_q;
    assign loop_depth   = ls_lvl;
    assign count_now    = cnt_q;
    assign overflow_err = err_q;

    assert_stacks_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_lvl == ls_lvl) && (pc_full == ls_full) && (pc_empty == ls_empty));
    assert_loop_back_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && loop_back) |=> (fetch_addr == $past(pc_top)));
    assert_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && loop_exit) |=> (fetch_addr == $past(end_top) + 1'b1)
                                 && (loop_depth == $past(loop_depth) - 1'b1));
    assert_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && loop_start && !ls_full && !at_end) |=>
            (loop_depth == $past(loop_depth) + 1'b1));
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && overflow_err) |=> overflow_err);
    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && loop_back && ce_loop && !count_load) |=>
            (count_now == $past(count_now) - 1'b1));
endmodule

// File: tb/zol_sequencer_bench.sv
module zol_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        loop_start = 1'b0;
    logic [13:0] loop_end_addr = '0;
    logic [3:0]  loop_cond = '0;
    logic        count_load = 1'b0;
    logic [13:0] count_value = '0;
    logic [7:0]  status_flags = '0;
    logic [13:0] fetch_addr;
    logic [2:0]  loop_depth;
    logic [13:0] count_now;
    logic        overflow_err;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [13:0] pc;
        logic [13:0] cnt;
        int          dep;
        logic        err;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    zol_sequencer u_zol_sequencer (
        .clk           (clk),
        .rst_n         (rst_n),
        .loop_start    (loop_start),
        .loop_end_addr (loop_end_addr),
        .loop_cond     (loop_cond),
        .count_load    (count_load),
        .count_value   (count_value),
        .status_flags  (status_flags),
        .fetch_addr    (fetch_addr),
        .loop_depth    (loop_depth),
        .count_now     (count_now),
        .overflow_err  (overflow_err)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: compares each cycle's outputs with the queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.req, "fetch_addr", int'(fetch_addr), int'(e.pc));
                check(e.req, "count_now", int'(count_now), int'(e.cnt));
                check(e.req, "loop_depth", int'(loop_depth), e.dep);
                check(e.req, "overflow_err", int'(overflow_err), int'(e.err));
            end
        end
    end

    // Driver: queue expectation for the current cycle, then clear commands.
    task automatic step(input int pc, input int cnt, input int dep, input logic err, input string req);
        exp_t e;
        e.pc = 14'(pc); e.cnt = 14'(cnt); e.dep = dep; e.err = err; e.req = req;
        exp_q.push_back(e);
        @(negedge clk);
        loop_start = 1'b0; count_load = 1'b0; status_flags = '0;
    endtask

    task automatic open_loop(input int end_addr, input logic [3:0] cond);
        loop_start = 1'b1; loop_end_addr = 14'(end_addr); loop_cond = cond;
    endtask

    task automatic load_count(input int v);
        count_load = 1'b1; count_value = 14'(v);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state, R2 sequential, R3/R4/R5/R7 counted loop of 3 x 3
        load_count(3);           step(0, 0, 0, 0, "R1");
        open_loop(4, 4'b0000);   step(1, 3, 0, 0, "R2");
        for (int it = 3; it >= 1; it--) begin
            step(2, it, 1, 0, "R3");
            step(3, it, 1, 0, "R4");
            step(4, it, 1, 0, "R7");
        end
        step(5, 0, 0, 0, "R5");
        step(6, 0, 0, 0, "R2");

        // R6 flag conditions on single-instruction loops (R9)
        do_reset();
        open_loop(1, 4'b1010);   step(0, 0, 0, 0, "R1");
        status_flags = 8'h08;    step(1, 0, 1, 0, "R6");
        step(1, 0, 1, 0, "R9");
        status_flags = 8'h04;    step(1, 0, 1, 0, "R6");
        open_loop(3, 4'b0011);   step(2, 0, 0, 0, "R5");
        status_flags = 8'h08;    step(3, 0, 1, 0, "R6");
        status_flags = 8'h0F;    step(3, 0, 1, 0, "R6");
        status_flags = 8'h00;    step(3, 0, 1, 0, "R6");
        step(4, 0, 0, 0, "R5");

        // R8 nested counted loops with count save and restore
        do_reset();
        load_count(2);           step(0, 0, 0, 0, "R1");
        open_loop(6, 4'b0000);   step(1, 2, 0, 0, "R3");
        load_count(2);           step(2, 2, 1, 0, "R8");
        open_loop(4, 4'b0000);   step(3, 2, 1, 0, "R8");
        step(4, 2, 2, 0, "R9");
        step(4, 1, 2, 0, "R7");
        step(5, 2, 1, 0, "R8");
        step(6, 2, 1, 0, "R4");
        load_count(2);           step(2, 1, 1, 0, "R8");
        open_loop(4, 4'b0000);   step(3, 2, 1, 0, "R8");
        step(4, 2, 2, 0, "R9");
        step(4, 1, 2, 0, "R7");
        step(5, 1, 1, 0, "R8");
        step(6, 1, 1, 0, "R8");
        step(7, 0, 0, 0, "R8");

        // R10 fifth loop ignored, error sticky, R9 four deep
        do_reset();
        open_loop(20, 4'b1000);  step(0, 0, 0, 0, "R1");
        open_loop(15, 4'b1000);  step(1, 0, 1, 0, "R9");
        open_loop(10, 4'b1000);  step(2, 0, 2, 0, "R9");
        open_loop(7, 4'b1000);   step(3, 0, 3, 0, "R9");
        open_loop(6, 4'b1000);   step(4, 0, 4, 0, "R9");
        step(5, 0, 4, 1, "R10");
        step(6, 0, 4, 1, "R10");
        status_flags = 8'h01;    step(7, 0, 4, 1, "R10");
        step(8, 0, 3, 1, "R5");
        step(9, 0, 3, 1, "R10");
        status_flags = 8'h01;    step(10, 0, 3, 1, "R5");
        step(11, 0, 2, 1, "R10");
        do_reset();
        step(0, 0, 0, 0, "R1");
        @(negedge clk);
        finish_run();
    end
endmodule